// File: doc/BRIEF.md
# Dual-Rail Token State Buffer

This block is a one-place storage stage for a state value carried on dual-rail wires. It comes out of reset already holding a token, the value given by a parameter, such as the start state of a handshake-driven state machine. It offers that token to its consumer before it has received anything, then takes the consumer's reply as the next value to hold. The next-state logic of a machine can therefore read the present state and write the new one through the same buffer, and no combinational loop forms.

Each bit uses two wires. The true rail high with the false rail low encodes 1. The false rail high with the true rail low encodes 0. Both rails low is the neutral (spacer) condition. A handshake round runs as follows:
1. The buffer waits until every input bit is neutral.
2. It presents the held value on the output rails.
3. A fully valid input word acknowledges that output. The buffer clears its internal rails and then loads the new value.
4. It returns its outputs to neutral.

The width is a parameter, and every bit is an instance of the same cell.

Top module: `dr_state_buffer`

## Requirements
- R1: Every bit is dual-rail, with (true=1, false=0) meaning 1, (0,1) meaning 0 and (0,0) meaning neutral. No output bit ever has both rails high.
- R2: While `rst` is high (synchronous, active high), every output rail is low, and the held value is set to `INIT_VALUE`.
- R3: The first word presented after reset is `INIT_VALUE`.
- R4: The output becomes valid only after a clock edge at which every input bit was neutral. It is valid at the edge that follows that sampling.
- R5: An input word in which only some bits are valid is ignored. The output keeps its value and stays valid.
- R6: When all input bits are valid while the output is presented, that word is captured. The next word presented equals it.
- R7: After the edge at which a fully valid input is sampled, the output stays valid for two more edges. It is neutral after the third edge.
- R8: After the output returns to neutral, it stays neutral for as long as any input bit is not neutral.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_t | input | WIDTH | True rails of the incoming next value |
| in_f | input | WIDTH | False rails of the incoming next value |
| out_t | output | WIDTH | True rails of the presented stored value |
| out_f | output | WIDTH | False rails of the presented stored value |

## Verification
The checker assumes an environment that keeps to the four-phase contract. No input bit ever drives both rails high. Once the input is fully valid, it stays fixed until the output has gone neutral. The bench acts as such an environment: it changes the input only at falling edges, and only in reply to what it observes on the output. It drives partially valid and partially neutral words only in those phases where the buffer must ignore them.

// File: rtl/dr_sbuf_pkg.sv
package dr_sbuf_pkg;

    typedef enum logic [1:0] {
        PH_AWAIT_NULL,
        PH_PRESENT,
        PH_WIPE,
        PH_LOAD
    } phase_e;

    typedef struct packed {
        logic emit;
        logic wipe;
        logic load;
        logic rtz;
    } cmd_t;

    localparam cmd_t CMD_IDLE = '{emit: 1'b0, wipe: 1'b0, load: 1'b0, rtz: 1'b0};

    function automatic logic rail_valid(input logic t, input logic f);
        return t != f;
    endfunction

    function automatic logic rail_null(input logic t, input logic f);
        return !t && !f;
    endfunction

endpackage

// File: rtl/dr_completion.sv
module dr_completion #(
    parameter int WIDTH = 2
) (
    input  logic [WIDTH-1:0] sig_t,
    input  logic [WIDTH-1:0] sig_f,
    output logic             all_valid,
    output logic             all_null
);
    import dr_sbuf_pkg::*;

    logic [WIDTH-1:0] bit_ok;
    logic [WIDTH-1:0] bit_zero;

    for (genvar i = 0; i < WIDTH; i++) begin : g_det
        assign bit_ok[i]   = rail_valid(sig_t[i], sig_f[i]);
        assign bit_zero[i] = rail_null(sig_t[i], sig_f[i]);
    end

    assign all_valid = &bit_ok;
    assign all_null  = &bit_zero;
endmodule

// File: rtl/dr_phase_ctrl.sv
module dr_phase_ctrl (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_all_valid,
    input  logic                in_all_null,
    output dr_sbuf_pkg::cmd_t   cmd
);
    import dr_sbuf_pkg::*;

    phase_e phase_q, phase_d;

    always_comb begin
        phase_d = phase_q;
        cmd     = CMD_IDLE;
        unique case (phase_q)
            PH_AWAIT_NULL: if (in_all_null) begin
                cmd.emit = 1'b1;
                phase_d  = PH_PRESENT;
            end
            PH_PRESENT: if (in_all_valid) begin
                cmd.wipe = 1'b1;
                phase_d  = PH_WIPE;
            end
            PH_WIPE: begin
                cmd.load = 1'b1;
                phase_d  = PH_LOAD;
            end
            PH_LOAD: begin
                cmd.rtz  = 1'b1;
                phase_d  = PH_AWAIT_NULL;
            end
            default: phase_d = PH_AWAIT_NULL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) phase_q <= PH_AWAIT_NULL;
        else     phase_q <= phase_d;
    end
endmodule

// File: rtl/dr_bit_cell.sv
module dr_bit_cell #(
    parameter logic INIT_BIT = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  dr_sbuf_pkg::cmd_t cmd,
    input  logic              in_t,
    input  logic              in_f,
    output logic              out_t,
    output logic              out_f
);
    // Internal state is itself dual-rail: wiped to neutral, then loaded.
    logic st_t, st_f;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_t <= INIT_BIT;
            st_f <= ~INIT_BIT;
        end else if (cmd.wipe) begin
            st_t <= 1'b0;
            st_f <= 1'b0;
        end else if (cmd.load) begin
            st_t <= in_t;
            st_f <= in_f;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_t <= 1'b0;
            out_f <= 1'b0;
        end else if (cmd.emit) begin
            out_t <= st_t;
            out_f <= st_f;
        end else if (cmd.rtz) begin
            out_t <= 1'b0;
            out_f <= 1'b0;
        end
    end
endmodule

// File: rtl/dr_state_buffer.sv
module dr_state_buffer #(
    parameter int               WIDTH      = 2,
    parameter logic [WIDTH-1:0] INIT_VALUE = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] in_t,
    input  logic [WIDTH-1:0] in_f,
    output logic [WIDTH-1:0] out_t,
    output logic [WIDTH-1:0] out_f
);
    import dr_sbuf_pkg::*;

    logic all_valid, all_null;
    cmd_t cmd;

    dr_completion #(.WIDTH(WIDTH)) u_cd (
        .sig_t     (in_t),
        .sig_f     (in_f),
        .all_valid (all_valid),
        .all_null  (all_null)
    );

    dr_phase_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .in_all_valid (all_valid),
        .in_all_null  (all_null),
        .cmd          (cmd)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        dr_bit_cell #(.INIT_BIT(INIT_VALUE[i])) u_cell (
            .clk   (clk),
            .rst   (rst),
            .cmd   (cmd),
            .in_t  (in_t[i]),
            .in_f  (in_f[i]),
            .out_t (out_t[i]),
            .out_f (out_f[i])
        );
    end
endmodule

// File: rtl/dr_state_buffer_chk.sv
module dr_state_buffer_chk #(
    parameter int WIDTH = 2
) (
    input logic             clk,
    input logic             rst,
    input logic [WIDTH-1:0] in_t,
    input logic [WIDTH-1:0] in_f,
    input logic [WIDTH-1:0] out_t,
    input logic [WIDTH-1:0] out_f
);
    logic in_full, in_empty, out_any, out_full;
    assign in_full  = ((in_t ^ in_f) == {WIDTH{1'b1}}) && ((in_t & in_f) == '0);
    assign in_empty = ((in_t | in_f) == '0);
    assign out_any  = |(out_t | out_f);
    assign out_full = ((out_t | out_f) == {WIDTH{1'b1}});

    AST_OUT_NO_CLASH: assert property (@(posedge clk) disable iff (rst)
        (out_t & out_f) == '0);                                        // R1

    AST_IN_NO_CLASH: assert property (@(posedge clk) disable iff (rst)
        (in_t & in_f) == '0);                                          // R1

    AST_RESET_NEUTRAL: assert property (@(posedge clk)
        rst |=> (out_t == '0 && out_f == '0));                         // R2

    AST_EMIT_AFTER_NULL: assert property (@(posedge clk) disable iff (rst)
        $rose(out_any) |-> ($past(in_empty) && out_full));             // R4

    AST_HOLD_ON_PARTIAL: assert property (@(posedge clk) disable iff (rst)
        (out_full && !in_full) |=> ($stable(out_t) && $stable(out_f))); // R5

    AST_RTZ_AFTER_DATA: assert property (@(posedge clk) disable iff (rst)
        $fell(out_any) |-> $past(in_full));                            // R7

    AST_STAY_NULL: assert property (@(posedge clk) disable iff (rst)
        (!out_any && !in_empty) |=> !out_any);                         // R8
endmodule

bind dr_state_buffer dr_state_buffer_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/dr_state_buffer_tb.sv
module dr_state_buffer_tb;
    localparam int          W          = 4;
    localparam logic [W-1:0] INIT      = 4'b1001;
    localparam time         CLK_PERIOD = 10ns;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] in_t = '0, in_f = '0;
    logic [W-1:0] out_t, out_f;

    int n_run = 0, n_fail = 0, cycles = 0;
    logic [W-1:0] exp_q[$];
    bit prev_valid = 1'b0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dr_state_buffer #(.WIDTH(W), .INIT_VALUE(INIT)) u_dut (
        .clk(clk), .rst(rst), .in_t(in_t), .in_f(in_f), .out_t(out_t), .out_f(out_f)
    );

    task automatic chk(input bit ok, input string req, input logic [2*W-1:0] act,
                       input logic [2*W-1:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit out_valid();
        return ((out_t ^ out_f) == {W{1'b1}});
    endfunction

    function automatic bit out_null();
        return ((out_t | out_f) == '0);
    endfunction

    // Monitor: every fresh presentation is compared with the scoreboard head.
    always @(negedge clk) begin
        if (rst) prev_valid = 1'b0;
        else begin
            if (out_valid() && !prev_valid) begin
                if (exp_q.size() == 0)
                    chk(1'b0, "R6 unexpected token", {out_t, out_f}, '0);
                else begin
                    logic [W-1:0] e;
                    e = exp_q.pop_front();
                    chk(out_t == e && (out_t & out_f) == '0, "R3/R6 R1 token value",
                        {out_t, out_f}, {e, ~e});
                end
            end
            prev_valid = out_valid();
        end
    end

    task automatic wait_valid();
        for (int i = 0; i < 50 && !out_valid(); i++) @(negedge clk);
        chk(out_valid(), "R4 output presented", {out_t, out_f}, '1);
    endtask

    // Driver: acts as the consumer replying with the next value.
    task automatic send(input logic [W-1:0] v, input bit partial, input int hold);
        logic [W-1:0] held_t;
        wait_valid();
        if (partial) begin
            held_t = out_t;
            in_t = {{(W-1){1'b0}}, v[0]};
            in_f = {{(W-1){1'b0}}, ~v[0]};
            repeat (3) begin
                @(negedge clk);
                chk(out_valid() && out_t == held_t, "R5 partial input ignored",
                    {out_t, out_f}, {held_t, ~held_t});
            end
        end
        in_t = v;
        in_f = ~v;
        exp_q.push_back(v);
        repeat (2) begin
            @(negedge clk);
            chk(out_valid(), "R7 output held after capture", {out_t, out_f}, '1);
        end
        @(negedge clk);
        chk(out_null(), "R7 return to neutral", {out_t, out_f}, '0);
        in_t = {{(W-1){1'b0}}, v[0]};
        in_f = {{(W-1){1'b0}}, ~v[0]};
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            chk(out_null(), "R8 neutral while input not neutral", {out_t, out_f}, '0);
        end
        in_t = '0;
        in_f = '0;
        @(negedge clk);
        chk(out_valid(), "R4 presented one cycle after neutral input", {out_t, out_f}, '1);
    endtask

    initial begin
        exp_q.push_back(INIT);
        repeat (3) @(negedge clk);
        chk(out_null(), "R2 neutral in reset", {out_t, out_f}, '0);
        rst = 1'b0;
        @(negedge clk);
        chk(out_valid(), "R3 token presented after reset", {out_t, out_f}, {INIT, ~INIT});
        send(4'b0011, 1'b0, 0);
        send(4'b1100, 1'b1, 2);
        send(4'b0000, 1'b0, 3);
        send(4'b1111, 1'b1, 0);
        send(4'b0101, 1'b0, 1);
        // Reset while a token is presented.
        @(negedge clk);
        rst = 1'b1;
        exp_q.delete();
        exp_q.push_back(INIT);
        repeat (2) @(negedge clk);
        chk(out_null(), "R2 neutral during mid-run reset", {out_t, out_f}, '0);
        rst = 1'b0;
        @(negedge clk);
        chk(out_t == INIT && out_valid(), "R2 R3 initial token after reset",
            {out_t, out_f}, {INIT, ~INIT});
        send(4'b1010, 1'b0, 0);
        send(4'b0110, 1'b1, 1);
        @(negedge clk);
        chk(exp_q.size() == 0, "R6 all tokens presented", exp_q.size(), 0);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog R4 actual=%0d expected=%0d", cycles, 20000);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule